// File: doc/BRIEF.md
# Scanline Sprite Countdown Mixer

This block produces one pixel per enabled cycle from up to eight sprites and a background pixel. A sprite fetcher outside the block loads each sprite into a slot. A slot holds a horizontal down-counter, a small attribute word and two 8-bit pattern shift registers: a low plane and a high plane. Each enabled cycle moves every counting slot one step closer to its start position. When a slot's counter reaches zero, the slot starts feeding pattern bits, one pair per enabled cycle, most significant bit first. After eight bits the slot falls silent.

Each slot runs a small state machine with three named states. S_EMPTY means the slot shows nothing. S_COUNT means the counter is running. S_SHIFT means the slot's pixel is visible and its shifters advance. The transitions are as follows:
- LOAD_WAIT (any state to S_COUNT) occurs on a load with a nonzero x.
- LOAD_NOW (any state to S_SHIFT) occurs on a load with x equal to zero.
- EXPIRE (S_COUNT to S_SHIFT) occurs on the enabled cycle that takes the counter from 1 to 0.
- DRAIN (S_SHIFT to S_EMPTY) occurs on the enabled cycle that shifts out the eighth bit.

A fixed-priority search picks the opaque sprite pixel in the lowest-numbered slot. A final multiplexer then chooses between that sprite pixel and the background pixel.

Top module: `spr_line_mixer`

## Requirements
- R1: After reset every slot is in S_EMPTY. While no slot is in S_SHIFT, `pix_out` equals `{1'b0, bg_pix}`.
- R2: A high `load_en[i]` on a clock edge captures the slot's x, attribute and both pattern planes, and restarts the slot. A load takes precedence over `cyc_en` in that slot during the same cycle.
- R3: In S_COUNT each edge with `cyc_en` high lowers the counter by one. During that time the slot contributes no pixel.
- R4: After a load with x = n > 0, the slot becomes visible after n enabled edges. Its pixel pattern is `{hi[7], lo[7]}` of the remaining shift contents, and each further enabled edge shifts both planes left by one bit.
- R5: A load with x = 0 makes the slot visible on the very next cycle, showing pattern bit 7.
- R6: After eight enabled edges in S_SHIFT the slot returns to S_EMPTY. It stays transparent until it is reloaded.
- R7: A sprite pixel whose two pattern bits are both 0 is transparent and never reaches `pix_out`.
- R8: Among visible opaque sprite pixels, the one in the lowest-numbered slot wins.
- R9: `load_attr` per slot is 3 bits: bit 2 puts the sprite behind the background, and bits 1:0 give the palette. The winning sprite is shown as `{1'b1, pal, pat}` when the background is transparent (`bg_pix[1:0]` = 0) or bit 2 is clear. Otherwise the output is `{1'b0, bg_pix}`.
- R10: With `cyc_en` low and no load, no slot changes its counter, shifters or state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cyc_en | input | 1 | Pixel-cycle enable: count and shift |
| load_en | input | NUM_SLOTS | Per-slot load strobe |
| load_x | input | NUM_SLOTS*X_W | Per-slot start position, slot i at bits i*X_W |
| load_attr | input | NUM_SLOTS*3 | Per-slot {behind, palette[1:0]} |
| load_lo | input | NUM_SLOTS*PAT_W | Per-slot low pattern plane |
| load_hi | input | NUM_SLOTS*PAT_W | Per-slot high pattern plane |
| bg_pix | input | 4 | Background {palette[1:0], pattern[1:0]} |
| pix_out | output | 5 | {sprite flag, palette[1:0], pattern[1:0]} |

## Verification
Two functions can fall in the same cycle in this block. The first case is a reload of a slot arriving on the same edge as a pixel-cycle enable, while that slot is counting or shifting. The second case is one slot expiring its counter while a lower- or higher-numbered slot is already showing an opaque pixel. The bench provokes the first case by reloading a slot mid-count with `cyc_en` high. It provokes the second by loading several slots with equal and staggered x values and mixed transparent bits. A behavioural per-slot model in the bench decides which slot and which plane bit must appear on every cycle, and the bench judges each cycle against it.

// File: rtl/spr_pkg.sv
package spr_pkg;

    localparam int PAL_W  = 2;
    localparam int ATTR_W = PAL_W + 1;
    localparam int BG_W   = PAL_W + 2;
    localparam int OUT_W  = BG_W + 1;

    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_COUNT = 2'd1,
        S_SHIFT = 2'd2
    } slot_st_t;

    typedef struct packed {
        logic             behind;
        logic [PAL_W-1:0] pal;
    } spr_attr_t;

    typedef struct packed {
        logic             opaque;
        logic             behind;
        logic [PAL_W-1:0] pal;
        logic [1:0]       pat;
    } spr_pix_t;

endpackage

// File: rtl/spr_slot.sv
module spr_slot
    import spr_pkg::*;
#(
    parameter int X_W   = 8,
    parameter int PAT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cyc_en,
    input  logic             ld,
    input  logic [X_W-1:0]   ld_x,
    input  spr_attr_t        ld_attr,
    input  logic [PAT_W-1:0] ld_lo,
    input  logic [PAT_W-1:0] ld_hi,
    output spr_pix_t         pix,
    output logic             active
);

    localparam int NSH_W = (PAT_W > 1) ? $clog2(PAT_W) : 1;

    slot_st_t         st_q, st_d;
    logic [X_W-1:0]   cnt_q;
    logic [PAT_W-1:0] lo_q, hi_q;
    spr_attr_t        attr_q;
    logic [NSH_W-1:0] nsh_q;
    logic             last_cnt, last_shift;

    assign last_cnt   = (cnt_q == X_W'(1));
    assign last_shift = (nsh_q == NSH_W'(PAT_W - 1));

    // next-state: LOAD_WAIT, LOAD_NOW, EXPIRE, DRAIN
    always_comb begin
        st_d = st_q;
        if (ld) begin
            st_d = (ld_x == '0) ? S_SHIFT : S_COUNT;
        end else if (cyc_en) begin
            unique case (st_q)
                S_EMPTY: st_d = S_EMPTY;
                S_COUNT: if (last_cnt)   st_d = S_SHIFT;
                S_SHIFT: if (last_shift) st_d = S_EMPTY;
                default: st_d = S_EMPTY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= S_EMPTY;
        else        st_q <= st_d;
    end

    // counter, pattern planes and attribute
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            lo_q   <= '0;
            hi_q   <= '0;
            attr_q <= '0;
            nsh_q  <= '0;
        end else if (ld) begin
            cnt_q  <= ld_x;
            lo_q   <= ld_lo;
            hi_q   <= ld_hi;
            attr_q <= ld_attr;
            nsh_q  <= '0;
        end else if (cyc_en) begin
            if (st_q == S_COUNT) begin
                cnt_q <= cnt_q - 1'b1;
            end
            if (st_q == S_SHIFT) begin
                lo_q  <= {lo_q[PAT_W-2:0], 1'b0};
                hi_q  <= {hi_q[PAT_W-2:0], 1'b0};
                nsh_q <= nsh_q + 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        active     = (st_q == S_SHIFT);
        pix.pat    = active ? {hi_q[PAT_W-1], lo_q[PAT_W-1]} : 2'b00;
        pix.opaque = |pix.pat;
        pix.pal    = attr_q.pal;
        pix.behind = attr_q.behind;
    end

endmodule

// File: rtl/spr_prio.sv
module spr_prio
    import spr_pkg::*;
#(
    parameter int N = 8
) (
    input  spr_pix_t [N-1:0] pix,
    output spr_pix_t         win,
    output logic [N-1:0]     win_oh
);

    // scan from the weakest slot down so the lowest index overwrites last
    always_comb begin
        win    = '0;
        win_oh = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pix[i].opaque) begin
                win       = pix[i];
                win_oh    = '0;
                win_oh[i] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/spr_mix.sv
module spr_mix
    import spr_pkg::*;
(
    input  spr_pix_t         sp,
    input  logic [BG_W-1:0]  bg,
    output logic [OUT_W-1:0] px
);

    logic bg_opq;
    logic show_spr;

    always_comb begin
        bg_opq   = |bg[1:0];
        show_spr = sp.opaque && (!bg_opq || !sp.behind);
        px       = show_spr ? {1'b1, sp.pal, sp.pat} : {1'b0, bg};
    end

endmodule

// File: rtl/spr_line_mixer.sv
module spr_line_mixer
    import spr_pkg::*;
#(
    parameter int NUM_SLOTS = 8,
    parameter int X_W       = 8,
    parameter int PAT_W     = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       cyc_en,
    input  logic [NUM_SLOTS-1:0]       load_en,
    input  logic [NUM_SLOTS*X_W-1:0]   load_x,
    input  logic [NUM_SLOTS*3-1:0]     load_attr,
    input  logic [NUM_SLOTS*PAT_W-1:0] load_lo,
    input  logic [NUM_SLOTS*PAT_W-1:0] load_hi,
    input  logic [3:0]                 bg_pix,
    output logic [4:0]                 pix_out
);

    spr_pix_t [NUM_SLOTS-1:0] slot_pix;
    logic     [NUM_SLOTS-1:0] slot_act;
    logic     [NUM_SLOTS-1:0] win_oh;
    spr_pix_t                 win_pix;

    for (genvar i = 0; i < NUM_SLOTS; i++) begin : g_slot
        spr_slot #(
            .X_W  (X_W),
            .PAT_W(PAT_W)
        ) u_slot (
            .clk    (clk),
            .rst_n  (rst_n),
            .cyc_en (cyc_en),
            .ld     (load_en[i]),
            .ld_x   (load_x[i*X_W +: X_W]),
            .ld_attr(spr_attr_t'(load_attr[i*ATTR_W +: ATTR_W])),
            .ld_lo  (load_lo[i*PAT_W +: PAT_W]),
            .ld_hi  (load_hi[i*PAT_W +: PAT_W]),
            .pix    (slot_pix[i]),
            .active (slot_act[i])
        );
    end

    spr_prio #(.N(NUM_SLOTS)) u_prio (
        .pix   (slot_pix),
        .win   (win_pix),
        .win_oh(win_oh)
    );

    spr_mix u_mix (
        .sp(win_pix),
        .bg(bg_pix),
        .px(pix_out)
    );

endmodule

// File: rtl/spr_line_mixer_chk.sv
module spr_line_mixer_chk #(
    parameter int N   = 8,
    parameter int X_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cyc_en,
    input logic [N-1:0]     load_en,
    input logic [N*X_W-1:0] load_x,
    input logic [3:0]       bg_pix,
    input logic [4:0]       pix_out,
    input logic [N-1:0]     slot_act,
    input logic [N-1:0]     win_oh
);

    logic [N-1:0] x_zero;
    logic [N-1:0] ld_now, ld_wait;

    always_comb begin
        for (int i = 0; i < N; i++) x_zero[i] = (load_x[i*X_W +: X_W] == '0);
        ld_now  = load_en & x_zero;
        ld_wait = load_en & ~x_zero;
    end

    assert_idle_bg_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_act == '0) |-> (pix_out == {1'b0, bg_pix}));

    assert_load_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wait != '0) |=> ((slot_act & $past(ld_wait)) == '0));

    assert_load_now_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_now != '0) |=> ((slot_act & $past(ld_now)) == $past(ld_now)));

    assert_spr_opaque_R7: assert property (@(posedge clk) disable iff (!rst_n)
        pix_out[4] |-> (pix_out[1:0] != 2'b00));

    assert_prio_onehot_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh));

    assert_prio_visible_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_oh & ~slot_act) == '0));

    assert_bg_front_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((win_oh != '0) && !pix_out[4]) |-> (bg_pix[1:0] != 2'b00));

    assert_freeze_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_en && (load_en == '0)) |=> $stable(slot_act));

endmodule

bind spr_line_mixer spr_line_mixer_chk #(
    .N  (NUM_SLOTS),
    .X_W(X_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cyc_en  (cyc_en),
    .load_en (load_en),
    .load_x  (load_x),
    .bg_pix  (bg_pix),
    .pix_out (pix_out),
    .slot_act(slot_act),
    .win_oh  (win_oh)
);

// File: tb/sim_spr_line_mixer.sv
module sim_spr_line_mixer;

    localparam int NS = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cyc_en = 1'b0;
    logic [7:0]   load_en = '0;
    logic [63:0]  load_x = '0;
    logic [23:0]  load_attr = '0;
    logic [63:0]  load_lo = '0;
    logic [63:0]  load_hi = '0;
    logic [3:0]   bg_pix = '0;
    logic [4:0]   pix_out;

    int    n_cmp = 0;
    int    n_bad = 0;
    int    cycles = 0;
    bit    rnd_bg = 0;
    string tag = "R1";

    // behavioural model: per sprite, mode 0 none, 1 waiting, 2 drawing
    int       m_mode[NS];
    int       m_wait[NS];
    int       m_drawn[NS];
    logic [7:0] m_lo[NS];
    logic [7:0] m_hi[NS];
    logic [2:0] m_at[NS];

    spr_line_mixer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .cyc_en   (cyc_en),
        .load_en  (load_en),
        .load_x   (load_x),
        .load_attr(load_attr),
        .load_lo  (load_lo),
        .load_hi  (load_hi),
        .bg_pix   (bg_pix),
        .pix_out  (pix_out)
    );

    always #4 clk = ~clk;

    always @(posedge clk) begin
        for (int i = 0; i < NS; i++) begin
            if (!rst_n) begin
                m_mode[i] = 0; m_wait[i] = 0; m_drawn[i] = 0;
                m_lo[i] = 0; m_hi[i] = 0; m_at[i] = 0;
            end else if (load_en[i]) begin
                m_wait[i]  = int'(load_x[i*8 +: 8]);
                m_lo[i]    = load_lo[i*8 +: 8];
                m_hi[i]    = load_hi[i*8 +: 8];
                m_at[i]    = load_attr[i*3 +: 3];
                m_drawn[i] = 0;
                m_mode[i]  = (m_wait[i] == 0) ? 2 : 1;
            end else if (cyc_en) begin
                if (m_mode[i] == 1) begin
                    m_wait[i] = m_wait[i] - 1;
                    if (m_wait[i] == 0) m_mode[i] = 2;
                end else if (m_mode[i] == 2) begin
                    m_lo[i] = m_lo[i] << 1;
                    m_hi[i] = m_hi[i] << 1;
                    m_drawn[i] = m_drawn[i] + 1;
                    if (m_drawn[i] == 8) m_mode[i] = 0;
                end
            end
        end
    end

    function automatic logic [4:0] model_pix();
        for (int i = 0; i < NS; i++) begin
            if (m_mode[i] == 2 && (m_hi[i][7] || m_lo[i][7])) begin
                if (bg_pix[1:0] == 2'b00 || !m_at[i][2])
                    return {1'b1, m_at[i][1:0], m_hi[i][7], m_lo[i][7]};
                return {1'b0, bg_pix};
            end
        end
        return {1'b0, bg_pix};
    endfunction

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            logic [4:0] exp_v;
            exp_v = model_pix();
            n_cmp++;
            if (pix_out !== exp_v) begin
                n_bad++;
                $display("FAIL %s t=%0t pix_out=%h expected=%h", tag, $time, pix_out, exp_v);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_cmp++;
            n_bad++;
            $display("FAIL R10 watchdog cycles=%0d expected<=150000", cycles);
            summary();
            $finish;
        end
    end

    task automatic put(int s, int x, logic [2:0] a, logic [7:0] lo, logic [7:0] hi);
        load_en[s]          = 1'b1;
        load_x[s*8 +: 8]    = 8'(x);
        load_attr[s*3 +: 3] = a;
        load_lo[s*8 +: 8]   = lo;
        load_hi[s*8 +: 8]   = hi;
    endtask

    task automatic run(int n, logic en);
        repeat (n) begin
            cyc_en = en;
            if (rnd_bg) bg_pix = 4'($urandom);
            @(negedge clk);
            #1;
            load_en = '0;
        end
    endtask

    initial begin
        bg_pix = 4'h7;
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        tag = "R1 reset state";
        run(3, 1'b1);

        tag = "R3 countdown";
        put(0, 5, 3'b001, 8'hFF, 8'h00);
        bg_pix = 4'h0;
        run(3, 1'b1);
        tag = "R10 enable low";
        run(4, 1'b0);
        tag = "R4 activation";
        run(12, 1'b1);

        tag = "R5 x zero";
        put(1, 0, 3'b010, 8'hA5, 8'h3C);
        run(6, 1'b1);
        tag = "R10 freeze mid-shift";
        run(3, 1'b0);
        tag = "R6 drain";
        run(6, 1'b1);

        tag = "R7 transparent bits";
        put(2, 2, 3'b000, 8'h0F, 8'h00);
        put(3, 2, 3'b011, 8'hFF, 8'hFF);
        run(14, 1'b1);

        tag = "R8 overlap priority";
        put(3, 3, 3'b001, 8'hF0, 8'h0F);
        put(4, 3, 3'b010, 8'hFF, 8'hFF);
        put(6, 1, 3'b011, 8'hFF, 8'h00);
        put(5, 4, 3'b000, 8'h5A, 8'hC3);
        run(16, 1'b1);

        tag = "R9 behind opaque bg";
        bg_pix = 4'b0110;
        put(0, 2, 3'b101, 8'hFF, 8'hFF);
        put(5, 6, 3'b011, 8'hFF, 8'h00);
        run(16, 1'b1);
        tag = "R9 behind clear bg";
        bg_pix = 4'b1100;
        put(0, 2, 3'b110, 8'hB1, 8'h4E);
        put(5, 6, 3'b011, 8'hFF, 8'h00);
        run(16, 1'b1);

        tag = "R2 reload during count";
        bg_pix = 4'h0;
        put(7, 4, 3'b001, 8'hFF, 8'hFF);
        run(2, 1'b1);
        put(7, 1, 3'b010, 8'h81, 8'h7E);
        run(12, 1'b1);
        tag = "R2 reload during shift";
        put(7, 0, 3'b011, 8'hFF, 8'h00);
        run(3, 1'b1);
        put(7, 2, 3'b001, 8'h00, 8'hF0);
        run(12, 1'b1);

        tag = "R8 R9 random";
        rnd_bg = 1;
        for (int k = 0; k < 600; k++) begin
            for (int s = 0; s < NS; s++) begin
                if ($urandom_range(0, 9) == 0)
                    put(s, $urandom_range(0, 20), 3'($urandom), 8'($urandom), 8'($urandom));
            end
            run(1, ($urandom_range(0, 4) != 0));
        end
        rnd_bg = 0;
        tag = "R6 all drained";
        run(40, 1'b1);

        summary();
        $finish;
    end

endmodule